// File: doc/BRIEF.md
# Packet Header Match/Mask Event Filter

This block watches packet headers as they leave a link port. For each header it reports whether the header agrees with a pattern that software has programmed. The pattern sits in two 32-bit match words, and two 32-bit mask words sit beside them. A mask bit set to one makes the matching header bit take part in the comparison. A mask bit of zero makes that header bit a don't-care. The header fields that can be compared are the remote node ID, the destination node ID, the message class, the opcode and the response data state. The 5-bit remote node ID is split between the two words.

A header qualifies when every selected bit equals the programmed bit. The response data state is an exception: it takes part only when the header carries the data-response class with an opcode of 0, 1 or 2. Otherwise its bits are treated as agreeing. Each valid header that qualifies produces a one-cycle pulse on the event output. That pulse is meant to drive a generic event counter whose event select is set to the match-count code 0x38.

Top module: `hmf_top`

## Requirements
- R1: After reset, all four configuration words read as zero and `match_evt` is low. With all-zero masks, every valid header produces a match pulse.
- R2: `match_evt` is high for exactly the one cycle that follows a clock edge at which `hdr_valid` was high and the header qualified. It is low after any edge at which `hdr_valid` was low. Back-to-back qualifying headers give back-to-back pulses.
- R3: `wr_addr` selects the word written: 0 is match word 0, 1 is match word 1, 2 is mask word 0 and 3 is mask word 1. A write is used for headers presented at later edges. A header presented at the same edge as a write is compared against the previous contents.
- R4: Word 0 layout: remote node ID bit 4 at bit 31, destination node ID at [17:13], message class at [12:9] and opcode at [8:5].
- R5: Word 1 layout: response data state at [19:16] and remote node ID bits 3:0 at [3:0]. Both parts of the remote node ID take part in the comparison.
- R6: Reserved bits (word 0 [30:18] and [4:0]; word 1 [31:20] and [15:4]) are discarded on write. Ones written there, in either the match word or the mask word, never change whether a header qualifies.
- R7: A header qualifies only if, for every mask bit set to one, the header bit equals the match bit. Unmasked bits may differ freely.
- R8: The response data state bits are compared only when the header class is 4'b1110 (data response) and the opcode is 0, 1 or 2. For any other class, or for opcode 3 or above, those bits count as agreeing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration word select |
| wr_data | input | 32 | Configuration write data |
| hdr_valid | input | 1 | Header fields valid this cycle |
| hdr_rnid | input | 5 | Remote node ID |
| hdr_dnid | input | 5 | Destination node ID |
| hdr_class | input | 4 | Message class |
| hdr_opcode | input | 4 | Opcode |
| hdr_rds | input | 4 | Response data state (one-hot, 0 = invalid) |
| match_evt | output | 1 | One-cycle match event pulse |

## Verification
A header sampled at clock edge n shows its result on `match_evt` after edge n and is read before edge n+1. There is one register on that path. A write taken at edge n affects only headers sampled at edge n+1 or later. The bench models both timings behaviourally and checks the output at every falling edge against the model's value for the previous rising edge. Each directed check samples exactly one falling edge after the stimulus edge, including the case where a write and a header arrive at the same edge.

// File: rtl/hmf_pkg.sv
package hmf_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int ADDR_W    = $clog2(NUM_WORDS);
  localparam int NID_W     = 5;
  localparam int CLS_W     = 4;
  localparam int OPC_W     = 4;
  localparam int RDS_W     = 4;
  localparam int NID_LO_W  = NID_W - 1;

  // word 0 field positions
  localparam int W0_NID_TOP = 31;
  localparam int W0_DST_LSB = 13;
  localparam int W0_CLS_LSB = 9;
  localparam int W0_OPC_LSB = 5;
  // word 1 field positions
  localparam int W1_RDS_LSB = 16;
  localparam int W1_NID_LSB = 0;

  localparam logic [WORD_W-1:0] W0_KEEP  = 32'h8003_FFE0;
  localparam logic [WORD_W-1:0] W1_KEEP  = 32'h000F_000F;
  localparam logic [WORD_W-1:0] RDS_BITS = 32'h000F_0000;

  localparam logic [CLS_W-1:0] CLS_DATA_RSP = 4'b1110;
  localparam logic [OPC_W-1:0] RDS_OPC_MAX  = 4'd2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PAT0  = 2'd0,
    SEL_PAT1  = 2'd1,
    SEL_SEL0  = 2'd2,
    SEL_SEL1  = 2'd3
  } word_sel_e;

  typedef struct packed {
    logic [WORD_W-1:0] pat0;
    logic [WORD_W-1:0] pat1;
    logic [WORD_W-1:0] sel0;
    logic [WORD_W-1:0] sel1;
  } cfg_t;

  function automatic logic [WORD_W-1:0] keep_of(input int idx);
    return (idx % 2 == 0) ? W0_KEEP : W1_KEEP;
  endfunction
endpackage

// File: rtl/hmf_regbank.sv
module hmf_regbank
  import hmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output cfg_t              cfg
);
  logic [WORD_W-1:0] word_q [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        word_q[g] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(g)))
        word_q[g] <= wr_data & keep_of(g);
    end
  end

  assign cfg.pat0 = word_q[int'(SEL_PAT0)];
  assign cfg.pat1 = word_q[int'(SEL_PAT1)];
  assign cfg.sel0 = word_q[int'(SEL_SEL0)];
  assign cfg.sel1 = word_q[int'(SEL_SEL1)];

  AST_PAT0_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == SEL_PAT0) |=> cfg.pat0 == ($past(wr_data) & W0_KEEP)); // R3
  AST_SEL1_RSV_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == SEL_SEL1) |=> cfg.sel1 == ($past(wr_data) & W1_KEEP)); // R6
  AST_UNADDRESSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> $stable(cfg)); // R3
endmodule

// File: rtl/hmf_hdr_pack.sv
module hmf_hdr_pack
  import hmf_pkg::*;
(
  input  logic [NID_W-1:0]  nid,
  input  logic [NID_W-1:0]  dst,
  input  logic [CLS_W-1:0]  cls,
  input  logic [OPC_W-1:0]  opc,
  input  logic [RDS_W-1:0]  rds,
  output logic [WORD_W-1:0] word0,
  output logic [WORD_W-1:0] word1
);
  always_comb begin
    word0 = '0;
    word0[W0_NID_TOP]                 = nid[NID_W-1];
    word0[W0_DST_LSB +: NID_W]        = dst;
    word0[W0_CLS_LSB +: CLS_W]        = cls;
    word0[W0_OPC_LSB +: OPC_W]        = opc;
    word1 = '0;
    word1[W1_RDS_LSB +: RDS_W]        = rds;
    word1[W1_NID_LSB +: NID_LO_W]     = nid[NID_LO_W-1:0];
  end
endmodule

// File: rtl/hmf_rds_qual.sv
module hmf_rds_qual
  import hmf_pkg::*;
(
  input  logic [CLS_W-1:0]  cls,
  input  logic [OPC_W-1:0]  opc,
  input  logic [WORD_W-1:0] sel1_raw,
  output logic [WORD_W-1:0] sel1_eff
);
  logic state_meaningful;

  assign state_meaningful = (cls == CLS_DATA_RSP) && (opc <= RDS_OPC_MAX);
  assign sel1_eff = state_meaningful ? sel1_raw : (sel1_raw & ~RDS_BITS);
endmodule

// File: rtl/hmf_word_cmp.sv
module hmf_word_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] hdr_bits,
  input  logic [W-1:0] pat_bits,
  input  logic [W-1:0] sel_bits,
  output logic         hit
);
  assign hit = ~|((hdr_bits ^ pat_bits) & sel_bits);
endmodule

// File: rtl/hmf_top.sv
module hmf_top
  import hmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              hdr_valid,
  input  logic [NID_W-1:0]  hdr_rnid,
  input  logic [NID_W-1:0]  hdr_dnid,
  input  logic [CLS_W-1:0]  hdr_class,
  input  logic [OPC_W-1:0]  hdr_opcode,
  input  logic [RDS_W-1:0]  hdr_rds,
  output logic              match_evt
);
  localparam int NUM_CMP = NUM_WORDS / 2;

  cfg_t              cfg;
  logic [WORD_W-1:0] hw   [NUM_CMP];
  logic [WORD_W-1:0] pat  [NUM_CMP];
  logic [WORD_W-1:0] sel  [NUM_CMP];
  logic [NUM_CMP-1:0] word_hit;
  logic [WORD_W-1:0] sel1_eff;
  logic              evt_q;

  hmf_regbank u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg)
  );

  hmf_hdr_pack u_pack (
    .nid(hdr_rnid), .dst(hdr_dnid), .cls(hdr_class), .opc(hdr_opcode),
    .rds(hdr_rds), .word0(hw[0]), .word1(hw[1])
  );

  hmf_rds_qual u_qual (
    .cls(hdr_class), .opc(hdr_opcode), .sel1_raw(cfg.sel1), .sel1_eff(sel1_eff)
  );

  assign pat[0] = cfg.pat0;
  assign pat[1] = cfg.pat1;
  assign sel[0] = cfg.sel0;
  assign sel[1] = sel1_eff;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    hmf_word_cmp #(.W(WORD_W)) u_cmp (
      .hdr_bits(hw[g]), .pat_bits(pat[g]), .sel_bits(sel[g]), .hit(word_hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= hdr_valid && (&word_hit);
  end

  assign match_evt = evt_q;

  AST_NO_EVT_WITHOUT_HDR: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> !match_evt); // R2
  AST_OPEN_MASK_PASSES: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && cfg.sel0 == '0 && cfg.sel1 == '0) |=> match_evt); // R1
  AST_RDS_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_class != CLS_DATA_RSP && cfg.sel0 == '0 &&
     (cfg.sel1 & ~RDS_BITS) == '0) |=> match_evt); // R8
  AST_NID_TOP_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && cfg.sel0[W0_NID_TOP] && (cfg.pat0[W0_NID_TOP] != hdr_rnid[NID_W-1]))
      |=> !match_evt); // R4
endmodule

// File: tb/hmf_top_bench.sv
module hmf_top_bench;
  localparam time CLK_PERIOD = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hdr_valid = 1'b0;
  logic [4:0]  hdr_rnid = '0, hdr_dnid = '0;
  logic [3:0]  hdr_class = '0, hdr_opcode = '0, hdr_rds = '0;
  logic        match_evt;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;

  logic [31:0] m_pat0 = '0, m_pat1 = '0, m_sel0 = '0, m_sel1 = '0;
  bit exp_evt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hmf_top u_hmf_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hdr_valid(hdr_valid), .hdr_rnid(hdr_rnid), .hdr_dnid(hdr_dnid),
    .hdr_class(hdr_class), .hdr_opcode(hdr_opcode), .hdr_rds(hdr_rds),
    .match_evt(match_evt)
  );

  // behavioural field-by-field model
  function automatic bit model_hit(input logic [4:0] rn, dn, input logic [3:0] c, o, s);
    bit ok = 1'b1;
    for (int b = 0; b < 5; b++) begin
      bit pb = (b == 4) ? m_pat0[31] : m_pat1[b];
      bit kb = (b == 4) ? m_sel0[31] : m_sel1[b];
      if (kb && pb != rn[b]) ok = 1'b0;
      if (m_sel0[13+b] && m_pat0[13+b] != dn[b]) ok = 1'b0;
    end
    for (int b = 0; b < 4; b++) begin
      if (m_sel0[9+b] && m_pat0[9+b] != c[b]) ok = 1'b0;
      if (m_sel0[5+b] && m_pat0[5+b] != o[b]) ok = 1'b0;
      if (c == 4'd14 && o <= 4'd2 && m_sel1[16+b] && m_pat1[16+b] != s[b]) ok = 1'b0;
    end
    return ok;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_evt <= 1'b0;
      m_pat0 <= '0; m_pat1 <= '0; m_sel0 <= '0; m_sel1 <= '0;
    end else begin
      exp_evt <= hdr_valid ? model_hit(hdr_rnid, hdr_dnid, hdr_class, hdr_opcode, hdr_rds) : 1'b0;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_pat0 <= wr_data;
          2'd1: m_pat1 <= wr_data;
          2'd2: m_sel0 <= wr_data;
          default: m_sel1 <= wr_data;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      checks++;
      if (match_evt !== exp_evt) begin
        fails++;
        $display("[TB] FAIL %s model: match_evt=%0b expected=%0b at %0t", cur_req, match_evt, exp_evt, $time);
      end
    end
  end

  task automatic idle();
    wr_en = 1'b0; hdr_valid = 1'b0;
  endtask

  task automatic step(input bit we, input logic [1:0] a, input logic [31:0] d,
                      input bit hv, input logic [4:0] rn, dn,
                      input logic [3:0] c, o, s);
    wr_en = we; wr_addr = a; wr_data = d;
    hdr_valid = hv; hdr_rnid = rn; hdr_dnid = dn;
    hdr_class = c; hdr_opcode = o; hdr_rds = s;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, '0, '0, '0, '0, '0);
  endtask

  task automatic hdr(input logic [4:0] rn, dn, input logic [3:0] c, o, s);
    step(1'b0, 2'd0, '0, 1'b1, rn, dn, c, o, s);
  endtask

  task automatic expect_evt(input bit e, input string req);
    checks++;
    if (match_evt !== e) begin
      fails++;
      $display("[TB] FAIL %s: match_evt=%0b expected=%0b at %0t", req, match_evt, e, $time);
    end
  endtask

  task automatic clear_cfg();
    wr(2'd0, '0); wr(2'd1, '0); wr(2'd2, '0); wr(2'd3, '0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("[TB] FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_evt(1'b0, "R1");
    model_on = 1'b1;

    // R1: zero masks pass everything
    cur_req = "R1";
    hdr(5'd31, 5'd7, 4'd14, 4'd1, 4'd8); expect_evt(1'b1, "R1");
    hdr(5'd0, 5'd0, 4'd0, 4'd15, 4'd0);  expect_evt(1'b1, "R1");

    // R2: pulse per header, low when idle
    cur_req = "R2";
    hdr(5'd1, 5'd2, 4'd3, 4'd4, 4'd0); expect_evt(1'b1, "R2");
    hdr(5'd1, 5'd2, 4'd3, 4'd4, 4'd0); expect_evt(1'b1, "R2");
    @(negedge clk); expect_evt(1'b0, "R2");

    // R4 / R7: destination node ID field at [17:13]
    cur_req = "R4";
    wr(2'd2, 32'h0003_E000);
    wr(2'd0, 32'd5 << 13);
    hdr(5'd0, 5'd5, 4'd0, 4'd0, 4'd0); expect_evt(1'b1, "R4");
    hdr(5'd0, 5'd4, 4'd0, 4'd0, 4'd0); expect_evt(1'b0, "R4");
    // class field at [12:9], opcode at [8:5]
    wr(2'd2, 32'h0000_1FE0);
    wr(2'd0, (32'd12 << 9) | (32'd9 << 5));
    hdr(5'd0, 5'd0, 4'd12, 4'd9, 4'd0); expect_evt(1'b1, "R4");
    hdr(5'd0, 5'd0, 4'd14, 4'd9, 4'd0); expect_evt(1'b0, "R4");
    hdr(5'd0, 5'd0, 4'd12, 4'd8, 4'd0); expect_evt(1'b0, "R4");

    // R5: split remote node ID
    cur_req = "R5";
    clear_cfg();
    wr(2'd2, 32'h8000_0000);
    wr(2'd3, 32'h0000_000F);
    wr(2'd0, 32'h8000_0000);
    wr(2'd1, 32'h0000_0006);
    hdr(5'b10110, 5'd0, 4'd0, 4'd0, 4'd0); expect_evt(1'b1, "R5");
    hdr(5'b00110, 5'd0, 4'd0, 4'd0, 4'd0); expect_evt(1'b0, "R5");
    hdr(5'b10111, 5'd0, 4'd0, 4'd0, 4'd0); expect_evt(1'b0, "R5");

    // R7: partial mask, only dnid bit 0 selected
    cur_req = "R7";
    clear_cfg();
    wr(2'd2, 32'h0000_2000);
    wr(2'd0, 32'h0000_2000);
    hdr(5'd9, 5'd31, 4'd5, 4'd6, 4'd1); expect_evt(1'b1, "R7");
    hdr(5'd9, 5'd30, 4'd5, 4'd6, 4'd1); expect_evt(1'b0, "R7");

    // R8: response data state qualified by class and opcode
    cur_req = "R8";
    clear_cfg();
    wr(2'd3, 32'h000F_0000);
    wr(2'd1, 32'h0008_0000);
    hdr(5'd0, 5'd0, 4'd14, 4'd1, 4'd8); expect_evt(1'b1, "R8");
    hdr(5'd0, 5'd0, 4'd14, 4'd2, 4'd4); expect_evt(1'b0, "R8");
    hdr(5'd0, 5'd0, 4'd14, 4'd3, 4'd4); expect_evt(1'b1, "R8");
    hdr(5'd0, 5'd0, 4'd12, 4'd0, 4'd4); expect_evt(1'b1, "R8");

    // R6: reserved bits discarded
    cur_req = "R6";
    clear_cfg();
    wr(2'd2, 32'h7FFC_001F);
    wr(2'd0, 32'h7FFC_001F);
    wr(2'd3, 32'hFFF0_FFF0);
    wr(2'd1, 32'hFFF0_FFF0);
    hdr(5'd0, 5'd0, 4'd0, 4'd0, 4'd0);   expect_evt(1'b1, "R6");
    hdr(5'd31, 5'd31, 4'd14, 4'd0, 4'd1); expect_evt(1'b1, "R6");

    // R3: write and header at the same edge
    cur_req = "R3";
    clear_cfg();
    wr(2'd2, 32'h0003_E000);
    wr(2'd0, 32'd3 << 13);
    step(1'b1, 2'd0, 32'd7 << 13, 1'b1, 5'd0, 5'd3, 4'd0, 4'd0, 4'd0);
    expect_evt(1'b1, "R3");
    hdr(5'd0, 5'd3, 4'd0, 4'd0, 4'd0); expect_evt(1'b0, "R3");
    hdr(5'd0, 5'd7, 4'd0, 4'd0, 4'd0); expect_evt(1'b1, "R3");
    wr(2'd1, 32'd7 << 13);
    hdr(5'd0, 5'd7, 4'd0, 4'd0, 4'd0); expect_evt(1'b1, "R3");

    // R7: mixed random traffic against the model
    cur_req = "R7";
    for (int i = 0; i < 600; i++) begin
      bit we = ($urandom_range(0, 3) == 0);
      logic [3:0] c = ($urandom_range(0, 1) == 0) ? 4'd14 : 4'($urandom);
      logic [31:0] d = ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom;
      step(we, 2'($urandom), d, ($urandom_range(0, 3) != 0),
           5'($urandom), 5'($urandom), c, 4'($urandom_range(0, 4)), 4'($urandom));
    end

    @(negedge clk);
    finish_run();
  end
endmodule